// File: doc/BRIEF.md
# Vectored Interrupt Controller Register Block

This block gathers ninety-six level-sensitive interrupt inputs, arranged as three banks of thirty-two, behind a small 32-bit register port. Each bank has three registers: a latched pending word, an enable word and a blocking mask word. A source is eligible when it is pending, enabled and not blocked. The eligible sources are ORed into a single request line to the processor.

A vector register reports the lowest-numbered eligible source, already scaled to a word offset. The value zero means that nothing needs service. The interrupt handler reads the vector, services the source it names, and clears that source's pending bit by writing a one to it. It then reads the vector again and repeats until the vector reads zero.

Two further storage registers are provided for software: a one-bit protection flag and a 32-bit external-interrupt control word. The block stores both but does not act on either of them. Reads from the register port are combinational on the address. A write commits on the rising clock edge at which the write strobe is high.

Top module: `vic_regblock`

## Requirements
- R1: A pending bit (bank n at byte offset 0x10+4n, bit i for source 32n+i) becomes 1 after any rising edge at which its source input is high, whether or not the source is enabled or masked.
- R2: Writing a 1 to a pending bit clears it, and writing 0 leaves it unchanged. If the source input is still high at the edge of the clearing write, setting takes priority and the bit reads 1 afterwards.
- R3: The enable words (0x40+4n) and mask words (0x50+4n) are read/write and reset to zero. A source contributes to the request and to the vector only if its enable bit is 1 and its mask bit is 0.
- R4: A read of offset 0x00 returns the number of the lowest-numbered eligible source, shifted left by two, with bits 1:0 equal to zero. It returns 0 when no source numbered 1 to 95 is eligible.
- R5: Source 0 is never reported by the vector, even when it is the only eligible source.
- R6: The output cpu_irq is high exactly when at least one source, source 0 included, is eligible.
- R7: Offset 0x08 holds a one-bit protection flag in bit 0, and its other bits read 0. Offset 0x0C holds a 32-bit control word. Both reset to 0.
- R8: Reads of unmapped offsets return 0. Writes to unmapped offsets, and writes to the vector offset, change no state.
- R9: After reset, every pending, enable and mask bit is 0 and cpu_irq is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_level | input | 96 | Level-sensitive interrupt inputs; bit k is source k |
| bus_addr | input | 8 | Byte offset of the register; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe; the write commits on the rising edge |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that the source inputs, address, data and strobe are stable around each rising edge and are free of X once reset is released. The bench meets this by changing every input on the falling edge only. The pending-capture property relies on reset being synchronous: it checks only updates made while rst_n was high, so the bench holds reset for several whole cycles and releases it on a falling edge. Source pulses last exactly one clock, which leaves the pending latch, rather than the live input level, as the only route to the request.

// File: rtl/vic_pkg.sv
// Package: shared register offsets for the vectored interrupt controller.
// Assumes byte addressing on an 8-bit offset, with word-aligned registers.
package vic_pkg;
    localparam logic [7:0] OFS_VECTOR    = 8'h00;
    localparam logic [7:0] OFS_PROTECT   = 8'h08;
    localparam logic [7:0] OFS_EXTCTRL   = 8'h0C;
    localparam logic [7:0] OFS_PEND_BASE = 8'h10;
    localparam logic [7:0] OFS_EN_BASE   = 8'h40;
    localparam logic [7:0] OFS_MASK_BASE = 8'h50;
endpackage

// File: rtl/vic_bank.sv
// Module: one bank of pending, enable and mask state for BANK_W sources.
// Pending bits latch the source level. A write-one clears a bit, but
// setting wins over clearing in the same cycle. Assumes synchronous
// active-low reset and write strobes that are already decoded by the parent.
module vic_bank #(
    parameter int BANK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] src,
    input  logic [BANK_W-1:0] pend_clr,
    input  logic              en_we,
    input  logic              mask_we,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] pend,
    output logic [BANK_W-1:0] en,
    output logic [BANK_W-1:0] mask,
    output logic [BANK_W-1:0] elig
);
    // Pending latch: a high source sets the bit, a written one clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~pend_clr) | src;
    end

    // Enable and mask words: plain read/write storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= '0;
            mask <= '0;
        end else begin
            if (en_we)   en   <= wdata;
            if (mask_we) mask <= wdata;
        end
    end

    // Eligibility: pending, enabled and not blocked.
    always_comb elig = pend & en & ~mask;

    AST_PEND_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((pend & $past(src)) == $past(src))); // R1
    AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && pend_clr == '0) |=> ((pend & $past(pend)) == $past(pend))); // R2
    AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((pend & $past(pend_clr) & ~$past(src)) == '0)); // R2
endmodule

// File: rtl/vic_prio.sv
// Module: fixed-priority picker. It returns the lowest-numbered set bit
// of elig, skipping bit 0, which is reserved to mean "none".
// Purely combinational; the clock and reset serve only the assertions.
module vic_prio #(
    parameter int N = 96,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     elig,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);
    // Scan downwards so that the lowest eligible index is assigned last.
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 1; i--) begin
            if (elig[i]) begin
                valid = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

    AST_WINNER_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (elig[idx] && idx != '0)); // R4
    AST_WINNER_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ((elig & ((N'(1) << idx) - N'(1)) & ~N'(1)) == '0)); // R4
    AST_NONE_MEANS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> ((elig & ~N'(1)) == '0)); // R5
endmodule

// File: rtl/vic_regblock.sv
// Module: top of the vectored interrupt controller. It decodes the
// register port, instantiates one vic_bank per bank, picks the vector
// and drives the request line. Reads are combinational on bus_addr.
// A write commits on the rising edge while bus_we is high.
module vic_regblock
    import vic_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    localparam int NUM_SRC  = NUM_BANKS * DATA_W,
    localparam int IDX_W    = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_level,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_we,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               cpu_irq
);
    logic [ADDR_W-1:0]  word_addr;
    logic [NUM_SRC-1:0] pend_all, en_all, mask_all, elig_all;
    logic               vec_valid;
    logic [IDX_W-1:0]   vec_idx;
    logic               prot_q;
    logic [DATA_W-1:0]  extctrl_q;

    // Word-align the address: the two low bits play no part in decode.
    always_comb word_addr = {bus_addr[ADDR_W-1:2], 2'b00};

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(OFS_PEND_BASE) + ADDR_W'(4 * b);
        localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(OFS_EN_BASE)   + ADDR_W'(4 * b);
        localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(OFS_MASK_BASE) + ADDR_W'(4 * b);
        logic [DATA_W-1:0] clr;

        // Write-one-to-clear data, present only during a pending write.
        always_comb clr = (bus_we && word_addr == PEND_A) ? bus_wdata : '0;

        vic_bank #(.BANK_W(DATA_W)) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .src     (src_level[b*DATA_W +: DATA_W]),
            .pend_clr(clr),
            .en_we   (bus_we && word_addr == EN_A),
            .mask_we (bus_we && word_addr == MASK_A),
            .wdata   (bus_wdata),
            .pend    (pend_all[b*DATA_W +: DATA_W]),
            .en      (en_all[b*DATA_W +: DATA_W]),
            .mask    (mask_all[b*DATA_W +: DATA_W]),
            .elig    (elig_all[b*DATA_W +: DATA_W])
        );
    end

    vic_prio #(.N(NUM_SRC)) prio_i (
        .clk  (clk),
        .rst_n(rst_n),
        .elig (elig_all),
        .valid(vec_valid),
        .idx  (vec_idx)
    );

    // Request line: any eligible source, source 0 included.
    always_comb cpu_irq = |elig_all;

    // Storage-only registers: protection flag and external control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_q    <= 1'b0;
            extctrl_q <= '0;
        end else if (bus_we) begin
            if (word_addr == ADDR_W'(OFS_PROTECT)) prot_q    <= bus_wdata[0];
            if (word_addr == ADDR_W'(OFS_EXTCTRL)) extctrl_q <= bus_wdata;
        end
    end

    // Read mux: unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (word_addr == ADDR_W'(OFS_VECTOR) && vec_valid)
            bus_rdata = DATA_W'({vec_idx, 2'b00});
        if (word_addr == ADDR_W'(OFS_PROTECT)) bus_rdata = DATA_W'(prot_q);
        if (word_addr == ADDR_W'(OFS_EXTCTRL)) bus_rdata = extctrl_q;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (word_addr == ADDR_W'(OFS_PEND_BASE) + ADDR_W'(4 * b))
                bus_rdata = pend_all[b*DATA_W +: DATA_W];
            if (word_addr == ADDR_W'(OFS_EN_BASE) + ADDR_W'(4 * b))
                bus_rdata = en_all[b*DATA_W +: DATA_W];
            if (word_addr == ADDR_W'(OFS_MASK_BASE) + ADDR_W'(4 * b))
                bus_rdata = mask_all[b*DATA_W +: DATA_W];
        end
    end

    AST_VEC_IMPLIES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> cpu_irq); // R6
    AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (word_addr == ADDR_W'(OFS_VECTOR)) |-> (bus_rdata[1:0] == 2'b00)); // R4
    AST_PROT_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (word_addr == ADDR_W'(OFS_PROTECT)) |-> (bus_rdata[DATA_W-1:1] == '0)); // R7
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !cpu_irq); // R9
endmodule

// File: tb/vic_regblock_tb.sv
// Bench: a table of register accesses walked by one loop, then directed
// tests for source capture, priority, clearing and corner cases.
module vic_regblock_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] src_level = '0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        cpu_irq;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    vic_regblock dut_i (
        .clk(clk), .rst_n(rst_n), .src_level(src_level),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
    );

    typedef struct packed {
        logic        rd;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } acc_t;

    localparam int NTBL = 17;
    localparam acc_t TBL [NTBL] = '{
        '{1'b1, 8'h40, 32'h0, 4'd9},          // R9 enable reset
        '{1'b1, 8'h50, 32'h0, 4'd9},          // R9 mask reset
        '{1'b1, 8'h0C, 32'h0, 4'd7},          // R7 control reset
        '{1'b0, 8'h08, 32'hFFFF_FFFF, 4'd7},
        '{1'b1, 8'h08, 32'h1, 4'd7},          // R7 one-bit flag
        '{1'b0, 8'h0C, 32'hA5A5_0003, 4'd7},
        '{1'b1, 8'h0C, 32'hA5A5_0003, 4'd7},  // R7 control word
        '{1'b0, 8'h44, 32'h30, 4'd3},
        '{1'b1, 8'h44, 32'h30, 4'd3},         // R3 enable rw
        '{1'b0, 8'h54, 32'h10, 4'd3},
        '{1'b1, 8'h54, 32'h10, 4'd3},         // R3 mask rw
        '{1'b0, 8'h04, 32'hFFFF_FFFF, 4'd8},
        '{1'b1, 8'h04, 32'h0, 4'd8},          // R8 unmapped read
        '{1'b1, 8'h44, 32'h30, 4'd8},         // R8 write ignored
        '{1'b0, 8'h00, 32'h1234, 4'd8},
        '{1'b1, 8'h00, 32'h0, 4'd8},          // R8 vector write ignored
        '{1'b1, 8'h60, 32'h0, 4'd8}           // R8 unmapped read
    };

    // One check: compare and count.
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Register write committed on the next rising edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    // Register read checked combinationally, away from the edge.
    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1 check(req, bus_rdata, exp);
    endtask

    // Single-cycle pulse on a set of sources.
    task automatic pulse(input logic [95:0] s);
        @(negedge clk);
        src_level = s;
        @(negedge clk);
        src_level = '0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1 check("R9 irq", {31'b0, cpu_irq}, 32'h0);
        rd("R9 pending", 8'h10, 32'h0);

        for (int i = 0; i < NTBL; i++) begin
            if (TBL[i].rd) rd($sformatf("R%0d table row %0d", TBL[i].req, i), TBL[i].addr, TBL[i].data);
            else           wr(TBL[i].addr, TBL[i].data);
        end

        // R1: source 36 is masked but is still captured.
        pulse(96'h1 << 36);
        rd("R1 capture masked", 8'h14, 32'h10);
        check("R3 masked no irq", {31'b0, cpu_irq}, 32'h0);
        rd("R3 masked no vector", 8'h00, 32'h0);
        wr(8'h54, 32'h0);
        rd("R4 vector 36", 8'h00, 32'h90);
        check("R6 irq on", {31'b0, cpu_irq}, 32'h1);

        // R4 priority, R2 selective clear.
        wr(8'h48, 32'h40);
        pulse((96'h1 << 37) | (96'h1 << 70));
        rd("R4 lowest wins", 8'h00, 32'h90);
        wr(8'h14, 32'h10);
        rd("R2 one cleared", 8'h14, 32'h20);
        rd("R4 next vector 37", 8'h00, 32'h94);
        wr(8'h14, 32'hFFFF_FFFF);
        rd("R4 vector 70", 8'h00, 32'h118);
        wr(8'h18, 32'hFFFF_FFFF);
        rd("R4 vector empty", 8'h00, 32'h0);
        check("R6 irq off", {31'b0, cpu_irq}, 32'h0);

        // R2: a clear while the source is held high does not stick.
        @(negedge clk);
        src_level = 96'h1 << 5;
        wr(8'h40, 32'h20);
        rd("R4 vector 5", 8'h00, 32'h14);
        wr(8'h10, 32'h20);
        rd("R2 held source resets", 8'h10, 32'h20);
        @(negedge clk);
        src_level = '0;
        wr(8'h10, 32'h20);
        rd("R2 released cleared", 8'h10, 32'h0);

        // R5: source 0 raises the request but is never a vector.
        wr(8'h40, 32'h1);
        pulse(96'h1);
        rd("R5 source zero hidden", 8'h00, 32'h0);
        check("R6 irq from source 0", {31'b0, cpu_irq}, 32'h1);
        wr(8'h10, 32'h1);

        // R3: masking the lowest source exposes the next one.
        wr(8'h40, 32'h108);
        pulse((96'h1 << 3) | (96'h1 << 8));
        wr(8'h50, 32'h8);
        rd("R3 mask skips 3", 8'h00, 32'h20);
        wr(8'h50, 32'h0);
        rd("R4 vector 3", 8'h00, 32'h0C);
        wr(8'h10, 32'hFFFF_FFFF);
        #1 check("R2 all cleared irq", {31'b0, cpu_irq}, 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule